// File: doc/BRIEF.md
# Supply-Qualified Power-Up Sequencer

This block is the synchronous controller that takes a calibration-class converter through power-up. Two digital flags come from external supply comparators. `lvl_low_ok` is the low arming level, and it already carries comparator hysteresis. `lvl_op_ok` is the higher level at which the logic can operate. After the operational flag has stayed high for a programmable number of cycles, the sequencer turns on the local load clock. It then steps a one-cycle-latency nonvolatile read port through every stored word, counting transfer cycles. When the count is complete, it turns the load clock off, commits the start code to the volatile working registers and enables the output. Three start codes are available: zero, midscale, or the stored preset.

While the supply is still coming up, the sequencer holds the clear strobe for the nonvolatile write latch high. This cancels any programming cycle that random flip-flop state may have started. If the operational flag drops at any point after arming, the run is abandoned and the sequencer waits for the flag again, with no partial register update. If the arming flag drops, everything returns to the power-down state. After the sequence completes, a host write port may change the volatile words. The stored words are not read again until the next power-up.

The state machine is one-hot. It has seven states. In IDLE the supply is below the arming level. ARMED waits for the operational flag. SETTLE is the stability wait. LOAD is the transfer. OSC_OFF stops the load clock and commits. OUT_ON drives the output. DONE opens host access. The transitions are as follows:
- arm: IDLE to ARMED.
- qualify: ARMED to SETTLE.
- settle-abort: SETTLE to ARMED.
- settled: SETTLE to LOAD.
- loaded: LOAD to OSC_OFF.
- commit: OSC_OFF to OUT_ON.
- ready: OUT_ON to DONE.
- op-abort: any later state back to ARMED.
- brown-out: any state to IDLE.

Any code that is not one-hot decodes as IDLE.

Top module: `por_seq_ctrl`

## Requirements
- R1: While `lvl_low_ok` is low the block is in power-down: `nv_wr_latch_clr` is 1, `osc_en`, `out_enable` and `por_done` are 0, `nv_addr` is 0 and every volatile word reads 0 one clock later.
- R2: Any clock edge that samples `lvl_low_ok` low returns the block to IDLE and clears the volatile words, whatever the state. A later rise restarts the complete sequence.
- R3: Once armed, `lvl_op_ok` must be sampled high on SETTLE_CYC consecutive edges after the qualifying edge before LOAD is entered. A low sample during the wait returns the block to ARMED, and the full wait then runs again.
- R4: LOAD lasts NUM_WORDS+1 cycles with `osc_en` high. `nv_addr` presents 0, 1, ... NUM_WORDS-1 on consecutive cycles, then 0. The word read at address k, returned one cycle later, is captured as stored word k.
- R5: After LOAD, one cycle follows with `osc_en` and `out_enable` both low. Then `out_enable` rises, and `por_done` rises one cycle after `out_enable`.
- R6: `nv_wr_latch_clr` is high in IDLE, ARMED and SETTLE, and low from LOAD onward.
- R7: The start code is committed to all words on the edge that leaves the OSC_OFF cycle. It is read from `start_mode` in that cycle: 00 gives zero, 01 gives midscale (only the top bit set), 10 gives the stored words, and 11 gives zero. Word i sits at `vol_regs[i*DATA_W +: DATA_W]`.
- R8: A low sample of `lvl_op_ok` in SETTLE, LOAD, OSC_OFF, OUT_ON or DONE returns the block to ARMED at that edge. `out_enable` and `osc_en` are then 0, and no volatile word changes.
- R9: A host write sampled while `por_done` is high replaces word `host_wr_addr` at that edge. A host write at any other time leaves every word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| lvl_low_ok | input | 1 | Arming comparator flag (with hysteresis); low acts as power-down |
| lvl_op_ok | input | 1 | Operational-level comparator flag |
| start_mode | input | 2 | Start code select (R7 encoding) |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_addr | input | ADDR_W | Host write word index |
| host_wr_data | input | DATA_W | Host write data |
| nv_addr | output | ADDR_W | Nonvolatile read address |
| nv_rdata | input | DATA_W | Nonvolatile read data, one cycle after address |
| osc_en | output | 1 | Load clock enable |
| nv_wr_latch_clr | output | 1 | Forces the nonvolatile write latch off |
| out_enable | output | 1 | Output driver enable |
| por_done | output | 1 | Sequence complete, host access open |
| vol_regs | output | NUM_WORDS*DATA_W | Volatile working words |

## Verification
The bench builds the block with DATA_W=8, NUM_WORDS=4 and SETTLE_CYC=5. A full power-up then takes about fifteen cycles, so one run can go through many sequences. These values also let it drop the operational flag inside the stability wait, in the middle of the transfer and after completion, and check each address step of the load. The short wait makes the exact wait length countable and exercises its restart after a glitch. Four words are enough to tell a shifted or misplaced capture apart from a correct one.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;

    typedef enum logic [6:0] {
        ST_IDLE    = 7'b0000001,
        ST_ARMED   = 7'b0000010,
        ST_SETTLE  = 7'b0000100,
        ST_LOAD    = 7'b0001000,
        ST_OSC_OFF = 7'b0010000,
        ST_OUT_ON  = 7'b0100000,
        ST_DONE    = 7'b1000000
    } por_state_e;

    localparam logic [1:0] MODE_ZERO = 2'b00;
    localparam logic [1:0] MODE_MID  = 2'b01;
    localparam logic [1:0] MODE_NV   = 2'b10;

endpackage

// File: rtl/por_seq_fsm.sv
module por_seq_fsm
    import por_seq_pkg::*;
#(
    parameter int NUM_WORDS  = 16,
    parameter int SETTLE_CYC = 1024,
    localparam int ADDR_W = $clog2(NUM_WORDS),
    localparam int LC_W   = $clog2(NUM_WORDS + 1),
    localparam int SC_W   = $clog2(SETTLE_CYC + 1)
) (
    input  logic              clk,
    input  logic              lvl_low_ok,
    input  logic              lvl_op_ok,
    output por_state_e        state_q,
    output logic [LC_W-1:0]   ld_cnt_q,
    output logic [ADDR_W-1:0] nv_addr,
    output logic              cap_en,
    output logic              commit_en,
    output logic              osc_en,
    output logic              nv_wr_latch_clr,
    output logic              out_enable,
    output logic              por_done
);

    por_state_e      state_d;
    logic [SC_W-1:0] sc_q, sc_d;
    logic [LC_W-1:0] lc_d;

    // next-state decode
    always_comb begin
        state_d = state_q;
        sc_d    = '0;
        lc_d    = '0;
        unique case (state_q)
            ST_IDLE:  state_d = ST_ARMED;
            ST_ARMED: if (lvl_op_ok) state_d = ST_SETTLE;
            ST_SETTLE: begin
                if (!lvl_op_ok)
                    state_d = ST_ARMED;
                else if (sc_q == SC_W'(SETTLE_CYC - 1))
                    state_d = ST_LOAD;
                else
                    sc_d = sc_q + SC_W'(1);
            end
            ST_LOAD: begin
                if (!lvl_op_ok)
                    state_d = ST_ARMED;
                else if (ld_cnt_q == LC_W'(NUM_WORDS))
                    state_d = ST_OSC_OFF;
                else
                    lc_d = ld_cnt_q + LC_W'(1);
            end
            ST_OSC_OFF: state_d = lvl_op_ok ? ST_OUT_ON : ST_ARMED;
            ST_OUT_ON:  state_d = lvl_op_ok ? ST_DONE : ST_ARMED;
            ST_DONE:    if (!lvl_op_ok) state_d = ST_ARMED;
            default:    state_d = ST_IDLE;
        endcase
        if (!lvl_low_ok) begin
            state_d = ST_IDLE;
            sc_d    = '0;
            lc_d    = '0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        state_q  <= state_d;
        sc_q     <= sc_d;
        ld_cnt_q <= lc_d;
    end

    // outputs
    always_comb begin
        osc_en          = 1'b0;
        nv_wr_latch_clr = 1'b0;
        out_enable      = 1'b0;
        por_done        = 1'b0;
        cap_en          = 1'b0;
        commit_en       = 1'b0;
        nv_addr         = '0;
        unique case (state_q)
            ST_IDLE, ST_ARMED, ST_SETTLE: nv_wr_latch_clr = 1'b1;
            ST_LOAD: begin
                osc_en = 1'b1;
                cap_en = 1'b1;
                if (ld_cnt_q < LC_W'(NUM_WORDS))
                    nv_addr = ld_cnt_q[ADDR_W-1:0];
            end
            ST_OSC_OFF: commit_en = lvl_op_ok & lvl_low_ok;
            ST_OUT_ON:  out_enable = 1'b1;
            ST_DONE: begin
                out_enable = 1'b1;
                por_done   = 1'b1;
            end
            default: nv_wr_latch_clr = 1'b1;
        endcase
    end

endmodule

// File: rtl/por_seq_loader.sv
module por_seq_loader #(
    parameter int DATA_W    = 8,
    parameter int NUM_WORDS = 16,
    localparam int LC_W = $clog2(NUM_WORDS + 1)
) (
    input  logic                        clk,
    input  logic                        cap_en,
    input  logic [LC_W-1:0]             ld_cnt,
    input  logic [DATA_W-1:0]           nv_rdata,
    output logic [NUM_WORDS*DATA_W-1:0] shadow_flat
);

    // data for address k returns while the count reads k+1
    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (cap_en && ld_cnt == LC_W'(i + 1))
                shadow_flat[i*DATA_W +: DATA_W] <= nv_rdata;
        end
    end

endmodule

// File: rtl/por_seq_regs.sv
module por_seq_regs
    import por_seq_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int NUM_WORDS = 16,
    localparam int ADDR_W = $clog2(NUM_WORDS)
) (
    input  logic                        clk,
    input  logic                        clr,
    input  logic                        commit_en,
    input  logic [1:0]                  start_mode,
    input  logic [NUM_WORDS*DATA_W-1:0] shadow_flat,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    output logic [NUM_WORDS*DATA_W-1:0] regs_flat
);

    localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        logic [DATA_W-1:0] start_val;

        always_comb begin
            unique case (start_mode)
                MODE_MID: start_val = MID_CODE;
                MODE_NV:  start_val = shadow_flat[i*DATA_W +: DATA_W];
                default:  start_val = '0;
            endcase
        end

        always_ff @(posedge clk) begin
            if (clr)
                regs_flat[i*DATA_W +: DATA_W] <= '0;
            else if (commit_en)
                regs_flat[i*DATA_W +: DATA_W] <= start_val;
            else if (wr_en && wr_addr == ADDR_W'(i))
                regs_flat[i*DATA_W +: DATA_W] <= wr_data;
        end
    end

endmodule

// File: rtl/por_seq_ctrl.sv
module por_seq_ctrl
    import por_seq_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int NUM_WORDS  = 16,
    parameter int SETTLE_CYC = 1024,
    localparam int ADDR_W = $clog2(NUM_WORDS)
) (
    input  logic                        clk,
    input  logic                        lvl_low_ok,
    input  logic                        lvl_op_ok,
    input  logic [1:0]                  start_mode,
    input  logic                        host_wr_en,
    input  logic [ADDR_W-1:0]           host_wr_addr,
    input  logic [DATA_W-1:0]           host_wr_data,
    output logic [ADDR_W-1:0]           nv_addr,
    input  logic [DATA_W-1:0]           nv_rdata,
    output logic                        osc_en,
    output logic                        nv_wr_latch_clr,
    output logic                        out_enable,
    output logic                        por_done,
    output logic [NUM_WORDS*DATA_W-1:0] vol_regs
);

    localparam int LC_W = $clog2(NUM_WORDS + 1);

    por_state_e                  state_q;
    logic [LC_W-1:0]             ld_cnt;
    logic                        cap_en;
    logic                        commit_en;
    logic [NUM_WORDS*DATA_W-1:0] shadow_flat;

    por_seq_fsm #(
        .NUM_WORDS (NUM_WORDS),
        .SETTLE_CYC(SETTLE_CYC)
    ) u_fsm (
        .clk            (clk),
        .lvl_low_ok     (lvl_low_ok),
        .lvl_op_ok      (lvl_op_ok),
        .state_q        (state_q),
        .ld_cnt_q       (ld_cnt),
        .nv_addr        (nv_addr),
        .cap_en         (cap_en),
        .commit_en      (commit_en),
        .osc_en         (osc_en),
        .nv_wr_latch_clr(nv_wr_latch_clr),
        .out_enable     (out_enable),
        .por_done       (por_done)
    );

    por_seq_loader #(
        .DATA_W   (DATA_W),
        .NUM_WORDS(NUM_WORDS)
    ) u_loader (
        .clk        (clk),
        .cap_en     (cap_en),
        .ld_cnt     (ld_cnt),
        .nv_rdata   (nv_rdata),
        .shadow_flat(shadow_flat)
    );

    por_seq_regs #(
        .DATA_W   (DATA_W),
        .NUM_WORDS(NUM_WORDS)
    ) u_regs (
        .clk        (clk),
        .clr        (!lvl_low_ok),
        .commit_en  (commit_en),
        .start_mode (start_mode),
        .shadow_flat(shadow_flat),
        .wr_en      (host_wr_en & por_done),
        .wr_addr    (host_wr_addr),
        .wr_data    (host_wr_data),
        .regs_flat  (vol_regs)
    );

endmodule

// File: rtl/por_seq_chk.sv
module por_seq_chk #(
    parameter int RW = 8
) (
    input logic          clk,
    input logic          lvl_low_ok,
    input logic          lvl_op_ok,
    input logic          osc_en,
    input logic          nv_wr_latch_clr,
    input logic          out_enable,
    input logic          por_done,
    input logic          commit_en,
    input logic [RW-1:0] vol_regs
);

    // R6
    latch_clr_off_in_load_chk: assert property (@(posedge clk) disable iff (!lvl_low_ok)
        osc_en |-> !nv_wr_latch_clr);

    // R4
    osc_out_exclusive_chk: assert property (@(posedge clk) disable iff (!lvl_low_ok)
        osc_en |-> !out_enable);

    // R5
    done_needs_output_chk: assert property (@(posedge clk) disable iff (!lvl_low_ok)
        por_done |-> out_enable);

    // R5
    output_after_gap_chk: assert property (@(posedge clk) disable iff (!lvl_low_ok)
        $rose(out_enable) |-> (!osc_en && !$past(osc_en)));

    // R8
    op_drop_abort_chk: assert property (@(posedge clk) disable iff (!lvl_low_ok)
        !lvl_op_ok |=> (!out_enable && !osc_en));

    // R9
    regs_frozen_chk: assert property (@(posedge clk) disable iff (!lvl_low_ok)
        (!por_done && !commit_en) |=> $stable(vol_regs));

endmodule

bind por_seq_ctrl por_seq_chk #(.RW(NUM_WORDS*DATA_W)) u_chk (
    .clk            (clk),
    .lvl_low_ok     (lvl_low_ok),
    .lvl_op_ok      (lvl_op_ok),
    .osc_en         (osc_en),
    .nv_wr_latch_clr(nv_wr_latch_clr),
    .out_enable     (out_enable),
    .por_done       (por_done),
    .commit_en      (commit_en),
    .vol_regs       (vol_regs)
);

// File: tb/tb_por_seq_ctrl.sv
module tb_por_seq_ctrl;

    localparam int DW = 8;
    localparam int NW = 4;
    localparam int SC = 5;
    localparam int AW = 2;

    localparam int M_IDLE = 0, M_ARMED = 1, M_SETTLE = 2, M_LOAD = 3,
                   M_OSCOFF = 4, M_OUTON = 5, M_DONE = 6;

    logic          clk = 1'b0;
    logic          lvl_low_ok = 1'b0;
    logic          lvl_op_ok = 1'b0;
    logic [1:0]    start_mode = 2'b10;
    logic          host_wr_en = 1'b0;
    logic [AW-1:0] host_wr_addr = '0;
    logic [DW-1:0] host_wr_data = '0;
    logic [AW-1:0] nv_addr;
    logic [DW-1:0] nv_rdata;
    logic          osc_en, nv_wr_latch_clr, out_enable, por_done;
    logic [NW*DW-1:0] vol_regs;

    logic [DW-1:0] nv_mem [NW];

    int vectors = 0;
    int fails   = 0;

    always #5 clk = ~clk;

    por_seq_ctrl #(.DATA_W(DW), .NUM_WORDS(NW), .SETTLE_CYC(SC)) dut (
        .clk(clk), .lvl_low_ok(lvl_low_ok), .lvl_op_ok(lvl_op_ok),
        .start_mode(start_mode), .host_wr_en(host_wr_en),
        .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
        .nv_addr(nv_addr), .nv_rdata(nv_rdata), .osc_en(osc_en),
        .nv_wr_latch_clr(nv_wr_latch_clr), .out_enable(out_enable),
        .por_done(por_done), .vol_regs(vol_regs)
    );

    // one-cycle-latency nonvolatile read port
    always @(posedge clk) nv_rdata <= nv_mem[nv_addr];

    // behavioural reference
    int            m_st = M_IDLE;
    int            m_sc = 0;
    int            m_lc = 0;
    logic [DW-1:0] m_reg [NW];
    logic [DW-1:0] m_sh  [NW];
    bit            started = 0;

    initial for (int i = 0; i < NW; i++) begin m_reg[i] = '0; m_sh[i] = '0; end

    always @(posedge clk) begin
        started = 1;
        if (!lvl_low_ok) begin
            m_st = M_IDLE; m_sc = 0; m_lc = 0;
            for (int i = 0; i < NW; i++) m_reg[i] = '0;
        end else begin
            case (m_st)
                M_IDLE:  m_st = M_ARMED;
                M_ARMED: if (lvl_op_ok) begin m_st = M_SETTLE; m_sc = 0; end
                M_SETTLE:
                    if (!lvl_op_ok) m_st = M_ARMED;
                    else if (m_sc == SC - 1) begin m_st = M_LOAD; m_lc = 0; end
                    else m_sc++;
                M_LOAD:
                    if (!lvl_op_ok) m_st = M_ARMED;
                    else begin
                        if (m_lc >= 1) m_sh[m_lc-1] = nv_mem[m_lc-1];
                        if (m_lc == NW) m_st = M_OSCOFF; else m_lc++;
                    end
                M_OSCOFF:
                    if (!lvl_op_ok) m_st = M_ARMED;
                    else begin
                        for (int i = 0; i < NW; i++)
                            m_reg[i] = (start_mode == 2'b01) ? 8'h80 :
                                       (start_mode == 2'b10) ? m_sh[i] : 8'h00;
                        m_st = M_OUTON;
                    end
                M_OUTON: m_st = lvl_op_ok ? M_DONE : M_ARMED;
                default:
                    if (!lvl_op_ok) m_st = M_ARMED;
                    else if (host_wr_en) m_reg[host_wr_addr] = host_wr_data;
            endcase
        end
    end

    function automatic logic [NW*DW-1:0] m_flat();
        logic [NW*DW-1:0] f;
        for (int i = 0; i < NW; i++) f[i*DW +: DW] = m_reg[i];
        return f;
    endfunction

    task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison, sampled away from the edge
    always @(posedge clk) begin
        #2;
        if (started) begin
            vectors++;
            cmp("R4", "osc_en", 32'(osc_en), 32'(m_st == M_LOAD));
            cmp("R4", "nv_addr", 32'(nv_addr),
                (m_st == M_LOAD && m_lc < NW) ? 32'(m_lc) : 32'd0);
            cmp("R6", "nv_wr_latch_clr", 32'(nv_wr_latch_clr), 32'(m_st <= M_SETTLE));
            cmp("R5", "out_enable", 32'(out_enable), 32'(m_st == M_OUTON || m_st == M_DONE));
            cmp("R5", "por_done", 32'(por_done), 32'(m_st == M_DONE));
            cmp("R7", "vol_regs", 32'(vol_regs), 32'(m_flat()));
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        cmp(tag, "directed", act, exp);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_osc(output int n);
        n = 0;
        while (!osc_en && n < 60) begin tick(1); n++; end
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!por_done && n < 80) begin tick(1); n++; end
        check(tag, 32'(por_done), 32'd1);
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int n;
        logic [NW*DW-1:0] snap;
        nv_mem[0] = 8'h11; nv_mem[1] = 8'h22; nv_mem[2] = 8'h33; nv_mem[3] = 8'h44;
        tick(4);
        // R1 power-down state
        check("R1", 32'(nv_wr_latch_clr), 32'd1);
        check("R1", 32'(vol_regs), 32'd0);
        check("R1", 32'({osc_en, out_enable, por_done}), 32'd0);

        lvl_low_ok = 1'b1;
        tick(2);
        check("R1", 32'(nv_wr_latch_clr), 32'd1);
        // R3 exact wait length
        lvl_op_ok = 1'b1;
        wait_osc(n);
        check("R3", 32'(n - 1), 32'(SC));
        wait_done("R5");
        // R7 stored preset
        check("R7", 32'(vol_regs), 32'h44332211);

        // R9 host write while done
        host_wr_en = 1'b1; host_wr_addr = 2'd2; host_wr_data = 8'hA5;
        tick(1);
        host_wr_en = 1'b0;
        check("R9", 32'(vol_regs), 32'h44A52211);

        // R8 abort from DONE
        snap = vol_regs;
        lvl_op_ok = 1'b0;
        tick(1);
        check("R8", 32'(out_enable), 32'd0);
        check("R8", 32'(vol_regs), 32'(snap));
        // R9 host write ignored while not done
        host_wr_en = 1'b1; host_wr_addr = 2'd1; host_wr_data = 8'h5A;
        tick(1);
        host_wr_en = 1'b0;
        check("R9", 32'(vol_regs), 32'(snap));

        // R3 glitch in settle restarts the wait
        start_mode = 2'b01;
        lvl_op_ok = 1'b1;
        tick(3);
        lvl_op_ok = 1'b0;
        tick(1);
        lvl_op_ok = 1'b1;
        wait_osc(n);
        check("R3", 32'(n - 1), 32'(SC));

        // R8 abort inside load
        tick(2);
        lvl_op_ok = 1'b0;
        tick(1);
        check("R8", 32'(osc_en), 32'd0);
        check("R8", 32'(vol_regs), 32'(snap));
        lvl_op_ok = 1'b1;
        wait_done("R7");
        check("R7", 32'(vol_regs), 32'h80808080);

        // R7 zero code
        lvl_op_ok = 1'b0; start_mode = 2'b00;
        tick(1);
        lvl_op_ok = 1'b1;
        wait_done("R7");
        check("R7", 32'(vol_regs), 32'd0);

        // R7 stored preset, then reserved code gives zero
        lvl_op_ok = 1'b0; start_mode = 2'b10;
        tick(1);
        lvl_op_ok = 1'b1;
        wait_done("R7");
        check("R7", 32'(vol_regs), 32'h44332211);
        lvl_op_ok = 1'b0; start_mode = 2'b11;
        tick(1);
        lvl_op_ok = 1'b1;
        wait_done("R7");
        check("R7", 32'(vol_regs), 32'd0);

        // R2 brown-out clears and restarts
        start_mode = 2'b10;
        lvl_op_ok = 1'b0;
        tick(1);
        lvl_op_ok = 1'b1;
        wait_done("R2");
        lvl_low_ok = 1'b0;
        tick(1);
        check("R2", 32'(vol_regs), 32'd0);
        check("R2", 32'(out_enable), 32'd0);
        nv_mem[0] = 8'hDE; nv_mem[1] = 8'hAD; nv_mem[2] = 8'hBE; nv_mem[3] = 8'hEF;
        tick(2);
        lvl_low_ok = 1'b1;
        wait_done("R2");
        check("R2", 32'(vol_regs), 32'hEFBEADDE);
        tick(2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule